// File: doc/BRIEF.md
# Channel Status and Interrupt Controller

This block collects the event flags of one receive channel and turns them into a single interrupt line. It holds four sticky flags: packet received, DMA transfer complete, DMA transfer error, and a latched copy of the receive almost-full condition. Each flag is set by its event and cleared by software writing a one to its bit position. The almost-full condition is produced inside the block by comparing the receive FIFO word count with a programmable level.

Each source passes through its own enable. The packet and almost-full sources, together with a force bit for testing, are also gated by a master enable. The DMA sources bypass the master enable and depend only on their own enable. The gated terms are ORed and registered to drive the interrupt output. A status bit reports whether any enabled non-DMA flag is pending, whatever the master enable is set to.

Software reaches the block through a plain register port: a single-cycle write strobe with address and data, and a combinational read of the selected address. Event inputs are single-cycle strobes. No stream interface exists, so no back-pressure applies.

Top module: `chan_irq_ctrl`

## Requirements
- R1: During reset the control register (address 0), the status flags (address 1, bits 0 to 3) and the level register (address 2) read as zero, and `irq` is low.
- R2: The packet flag (status bit 0) is set by a `ev_pkt` strobe and stays set until a write to address 1 with data bit 0 set. A write whose bit is zero leaves the flag unchanged.
- R3: The DMA-complete flag (status bit 2) and the DMA-error flag (status bit 3) are set by `ev_dma_done` and `ev_dma_err` and are cleared by writing one to their bit at address 1.
- R4: When a clearing write and the setting event for the same flag fall in one cycle, the flag stays set.
- R5: Status bit 4 reads one while `fifo_count` is greater than or equal to the level register. Status bit 1 is a sticky copy: it is set in any cycle in which that condition holds, stays set after the count falls, and clears by writing one to bit 1.
- R6: Control bit 0 is the master enable. While it is zero, the packet flag, the almost-full flag and the force bit do not raise `irq`, but the flags still read back.
- R7: With control bit 4 (DMA enable) set, a set DMA-complete or DMA-error flag raises `irq` whether the master enable is set or not.
- R8: Control bit 1 (force) raises `irq` only when the master enable is also set.
- R9: Status bit 5 reads one when the packet flag is set with control bit 2 (packet enable) set, or the sticky almost-full flag is set with control bit 3 (almost-full enable) set, whatever the master enable is set to.
- R10: `irq` is registered: it reflects the flag and control state one clock after that state is visible at the read port.
- R11: Address 0 holds control bits 4:0 (master, force, packet enable, almost-full enable, DMA enable) and address 2 holds the almost-full level. Both read back what was last written, and unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| ev_pkt | input | 1 | Packet received strobe |
| ev_dma_done | input | 1 | DMA transfer complete strobe |
| ev_dma_err | input | 1 | DMA transfer error strobe |
| fifo_count | input | 12 | Receive FIFO word count |
| irq | output | 1 | Interrupt request |

## Verification
A flag that drops on its own, or fails to set, shows at the read port one clock after the event and on `irq` one clock after that. A wrong gating term shows on `irq` two clocks after an event or one clock after a control write. A corrupted level register shows at once in status bit 4. The bench therefore samples every result at fixed offsets from its stimulus, and that exposes stuck, lost or mis-gated state within two cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned CTRL_W = 5;
  localparam int unsigned C_MASTER = 0;
  localparam int unsigned C_FORCE  = 1;
  localparam int unsigned C_PKT_IE = 2;
  localparam int unsigned C_AF_IE  = 3;
  localparam int unsigned C_DMA_IE = 4;

  localparam int unsigned NFLAG = 4;
  localparam int unsigned F_PKT  = 0;
  localparam int unsigned F_AF   = 1;
  localparam int unsigned F_DONE = 2;
  localparam int unsigned F_ERR  = 3;
  localparam int unsigned S_LIVE = 4;
  localparam int unsigned S_ACT  = 5;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_STAT  = 2'd1;
  localparam logic [1:0] A_LEVEL = 2'd2;
endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R4: an event in the clearing cycle keeps the flag
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R2: a set flag holds until cleared
  a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  // R3: a clear with no event drops the flag
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] level_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] level_o,
  output logic             hit_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    level_o <= '0;
    else if (ld_i) level_o <= level_i;
  end

  assign hit_o = (count_i >= level_o);

  // R11: level only changes on a write
  a_r11_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(level_o));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [NFLAG-1:0]  flag_i,
  output logic              active_o,
  output logic              irq_o
);
  logic host_term;
  logic dma_term;

  assign active_o  = (flag_i[F_PKT] & ctrl_i[C_PKT_IE]) |
                     (flag_i[F_AF]  & ctrl_i[C_AF_IE]);
  assign host_term = ctrl_i[C_MASTER] & (active_o | ctrl_i[C_FORCE]);
  assign dma_term  = ctrl_i[C_DMA_IE] & (flag_i[F_DONE] | flag_i[F_ERR]);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= host_term | dma_term;
  end

  // R7: DMA sources bypass the master enable
  a_r7_dma_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[C_DMA_IE] && (flag_i[F_DONE] || flag_i[F_ERR])) |=> irq_o);
  // R6: without master and DMA enable, no interrupt
  a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i[C_MASTER] && !ctrl_i[C_DMA_IE]) |=> !irq_o);
  // R8: force with master raises the line
  a_r8_force: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[C_MASTER] && ctrl_i[C_FORCE]) |=> irq_o);
endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_pkt,
  input  logic              ev_dma_done,
  input  logic              ev_dma_err,
  input  logic [CNT_W-1:0]  fifo_count,
  output logic              irq
);
  localparam int unsigned STAT_W = NFLAG + 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NFLAG-1:0]  flag_set, flag_clr, flags;
  logic [CNT_W-1:0]  level;
  logic              af_live, active;
  logic              wr_ctrl, wr_stat, wr_level;

  assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign wr_stat  = wr_en && (wr_addr == ADDR_W'(A_STAT));
  assign wr_level = wr_en && (wr_addr == ADDR_W'(A_LEVEL));

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  irq_level_cmp #(.CNT_W(CNT_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .ld_i(wr_level),
    .level_i(wr_data[CNT_W-1:0]), .count_i(fifo_count),
    .level_o(level), .hit_o(af_live)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[F_PKT]  = ev_pkt;
    flag_set[F_AF]   = af_live;
    flag_set[F_DONE] = ev_dma_done;
    flag_set[F_ERR]  = ev_dma_err;
  end

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      assign flag_clr[i] = wr_stat && wr_data[i];
      irq_sticky_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(flag_set[i]),
        .clr_i(flag_clr[i]), .flag_o(flags[i])
      );
    end
  endgenerate

  irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_q), .flag_i(flags),
    .active_o(active), .irq_o(irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(A_CTRL):  rd_data[CTRL_W-1:0] = ctrl_q;
      ADDR_W'(A_STAT):  rd_data[STAT_W-1:0] = {active, af_live, flags};
      ADDR_W'(A_LEVEL): rd_data[CNT_W-1:0]  = level;
      default:          rd_data = '0;
    endcase
  end

  // R5: sticky copy follows the live condition
  a_r5_af_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    af_live |=> flags[F_AF]);
  // R2: packet event reaches the status port
  a_r2_pkt_seen: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pkt |=> flags[F_PKT]);
  // R11: control changes only on a write
  a_r11_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: tb/sim_chan_irq_ctrl.sv
`timescale 1ns/1ps
module sim_chan_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic        ev_pkt = 0, ev_dma_done = 0, ev_dma_err = 0;
  logic [11:0] fifo_count = 0;
  logic        irq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  chan_irq_ctrl u0 (.*);

  typedef struct packed {
    logic [4:0]  ctrl;
    logic [2:0]  ev;    // {err, done, pkt}
    logic [11:0] cnt;
    logic        irq;
    logic [5:0]  st;
  } vec_t;

  // level 8 for every vector
  localparam vec_t VEC [11] = '{
    '{5'h00, 3'b001, 12'd0, 1'b0, 6'd1},   // R6 flag readable, no irq
    '{5'h05, 3'b001, 12'd0, 1'b1, 6'd33},  // R6 R9
    '{5'h04, 3'b001, 12'd0, 1'b0, 6'd33},  // R9 active without master
    '{5'h10, 3'b010, 12'd0, 1'b1, 6'd4},   // R7 R3 done bypass
    '{5'h10, 3'b100, 12'd0, 1'b1, 6'd8},   // R7 R3 err bypass
    '{5'h09, 3'b000, 12'd8, 1'b1, 6'd50},  // R5 count == level
    '{5'h09, 3'b000, 12'd7, 1'b0, 6'd0},   // R5 count below level
    '{5'h03, 3'b000, 12'd0, 1'b1, 6'd0},   // R8 force with master
    '{5'h02, 3'b000, 12'd0, 1'b0, 6'd0},   // R8 force without master
    '{5'h05, 3'b010, 12'd0, 1'b0, 6'd4},   // R7 dma not enabled
    '{5'h1F, 3'b111, 12'd9, 1'b1, 6'd63}   // all sources
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    tick(); tick();
    rd_chk("R1 ctrl", 2'd0, 16'h0);
    rd_chk("R1 flags", 2'd1, 16'h10);  // live bit only: 0 >= 0
    rd_chk("R1 level", 2'd2, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);
    rst_n = 1;
    tick();
    wr(2'd2, 16'd8);
    wr(2'd1, 16'hF);
    rd_chk("R11 level readback", 2'd2, 16'd8);

    foreach (VEC[i]) begin
      fifo_count = 0;
      wr(2'd0, 16'h0);
      wr(2'd1, 16'hF);
      wr(2'd0, {11'd0, VEC[i].ctrl});
      fifo_count = VEC[i].cnt;
      {ev_dma_err, ev_dma_done, ev_pkt} = VEC[i].ev;
      tick();
      {ev_dma_err, ev_dma_done, ev_pkt} = 3'b000;
      tick();
      rd_chk($sformatf("vec%0d status", i), 2'd1, {10'd0, VEC[i].st});
      chk($sformatf("vec%0d irq", i), {15'd0, irq}, {15'd0, VEC[i].irq});
    end
    rd_chk("R11 ctrl readback", 2'd0, 16'h1F);

    // R2 R3: partial clear, zero write
    fifo_count = 0;
    wr(2'd0, 16'h0);
    wr(2'd1, 16'hF);
    ev_pkt = 1; ev_dma_done = 1; tick(); ev_pkt = 0; ev_dma_done = 0;
    wr(2'd1, 16'h1);
    rd_chk("R2 pkt cleared only", 2'd1, 16'h4);
    wr(2'd1, 16'h0);
    rd_chk("R2 zero write ignored", 2'd1, 16'h4);
    wr(2'd1, 16'h4);
    rd_chk("R3 done cleared", 2'd1, 16'h0);

    // R4 clear and event in the same cycle
    ev_pkt = 1; wr(2'd1, 16'h1); ev_pkt = 0;
    rd_chk("R4 event wins", 2'd1, 16'h1);
    wr(2'd1, 16'h1);

    // R5 sticky after count drops
    wr(2'd2, 16'd4);
    fifo_count = 5; tick(); fifo_count = 0;
    rd_chk("R5 sticky held", 2'd1, 16'h2);
    wr(2'd1, 16'h2);
    rd_chk("R5 sticky cleared", 2'd1, 16'h0);

    // R10 latency on clear
    wr(2'd0, 16'h05);
    ev_pkt = 1; tick(); ev_pkt = 0;
    tick();
    chk("R10 irq raised", {15'd0, irq}, 16'h1);
    wr(2'd1, 16'h1);
    chk("R10 irq one cycle late", {15'd0, irq}, 16'h1);
    tick();
    chk("R10 irq dropped", {15'd0, irq}, 16'h0);

    // R6 master toggled on a pending flag
    wr(2'd0, 16'h04);
    ev_pkt = 1; tick(); ev_pkt = 0; tick();
    chk("R6 masked", {15'd0, irq}, 16'h0);
    wr(2'd0, 16'h05);
    chk("R10 after master write", {15'd0, irq}, 16'h0);
    tick();
    chk("R6 unmasked", {15'd0, irq}, 16'h1);
    rd_chk("R11 unused addr", 2'd3, 16'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule